// File: doc/BRIEF.md
# T1 Receive Loss-of-Signal Detector

This block watches the receive side of a T1 line and raises a loss-of-signal flag when the line goes quiet. It has two sources. The first counts bit periods in a row in which neither the positive nor the negative rail carried a pulse. The second is a low-amplitude flag from the analog front end. That flag arrives without regard to the local clock, so it is synchronised first. The flag output is the OR of the two conditions.

While loss is flagged, both receive data outputs are held low. Recovery of the data carries on underneath. Rails are still captured on every bit strobe, and a pulse still clears the zero run. Normal output therefore returns as soon as valid data is seen and the amplitude flag has dropped.

Zero counting only runs while the oversampling clock is reported present. Without that clock the recovered bit timing cannot be trusted, so the run is held at zero.

Top module: `t1_los_detect`

## Requirements
- R1: After reset, `los_out`, `rx_pos_out` and `rx_neg_out` are 0 and the zero run length is 0.
- R2: With `osc_present` high, `los_out` rises on the clock edge that takes the THRESH-th consecutive bit strobe with both rails low (default 175). After THRESH-1 such strobes it is still 0. Cycles without `bit_stb` neither advance nor clear the run.
- R3: The run length saturates at THRESH. `los_out` stays 1 while zero bits continue beyond the threshold.
- R4: A bit strobe with `rx_pos_in` or `rx_neg_in` high clears the run to 0. The zero-run loss condition then ends on that same clock edge.
- R5: While `osc_present` is 0, the run is cleared on every clock and held at 0. Zero bits then cannot cause loss, and a loss due to zeros ends one clock after `osc_present` falls.
- R6: `low_amp_in` passes through a SYNC_STAGES-flop synchroniser (default 2). It affects `los_out` on the second clock edge after it changes.
- R7: `los_out` is high whenever either the zero-run condition or the synchronised amplitude flag is high. Removing one source leaves loss asserted while the other holds.
- R8: While `los_out` is 1, `rx_pos_out` and `rx_neg_out` are both 0.
- R9: While `los_out` is 0, `rx_pos_out` and `rx_neg_out` show the rails captured at the most recent bit strobe, held until the next strobe.
- R10: Rails captured during loss are kept. When loss ends without a new strobe, the outputs show the last rails captured while loss was asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-clock strobe per recovered bit period |
| rx_pos_in | input | 1 | Positive-rail pulse for the current bit |
| rx_neg_in | input | 1 | Negative-rail pulse for the current bit |
| low_amp_in | input | 1 | Asynchronous low-amplitude flag from the analog front end |
| osc_present | input | 1 | High while the oversampling clock is running |
| los_out | output | 1 | Loss-of-signal flag |
| rx_pos_out | output | 1 | Positive rail data, squelched during loss |
| rx_neg_out | output | 1 | Negative rail data, squelched during loss |

## Verification
A run counter that is wrong by even one count moves the edge of `los_out` by one bit strobe, so the bench checks one bit short of the threshold and then exactly at it. A counter that fails to clear on a pulse, or while the oversampling clock is absent, keeps `los_out` high on the next sampled clock and squelches the data that should pass. A synchroniser with the wrong depth moves the amplitude response by a clock, which the one-cycle and two-cycle samples show. A lost rail capture shows as the wrong value on the data outputs when loss ends.

// File: rtl/t1los_pkg.sv
package t1los_pkg;

  // Next value of the zero-run counter for one clock.
  function automatic int unsigned zero_run_next(
    input int unsigned cur,
    input logic        stb,
    input logic        mark,
    input logic        run,
    input int unsigned limit
  );
    if (!run)          return 0;
    if (!stb)          return cur;
    if (mark)          return 0;
    if (cur >= limit)  return limit;
    return cur + 1;
  endfunction

  function automatic logic zero_run_reached(
    input int unsigned cur,
    input int unsigned limit
  );
    return cur >= limit;
  endfunction

endpackage

// File: rtl/t1los_sync.sv
module t1los_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/t1los_zero_run.sv
module t1los_zero_run #(
  parameter int THRESH = 175,
  parameter int CNT_W  = $clog2(THRESH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             mark_seen,
  input  logic             osc_present,
  output logic [CNT_W-1:0] run_len,
  output logic             run_los
);
  import t1los_pkg::*;

  logic [CNT_W-1:0] run_len_d;

  always_comb begin
    run_len_d = CNT_W'(zero_run_next(32'(run_len), bit_stb, mark_seen,
                                     osc_present, THRESH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= run_len_d;
  end

  assign run_los = zero_run_reached(32'(run_len), THRESH);
endmodule

// File: rtl/t1los_rail_gate.sv
module t1los_rail_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic pos_in,
  input  logic neg_in,
  input  logic squelch,
  output logic pos_out,
  output logic neg_out
);
  logic pos_q, neg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else if (bit_stb) begin
      pos_q <= pos_in;
      neg_q <= neg_in;
    end
  end

  assign pos_out = pos_q & ~squelch;
  assign neg_out = neg_q & ~squelch;
endmodule

// File: rtl/t1_los_detect.sv
module t1_los_detect #(
  parameter int THRESH      = 175,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic rx_pos_in,
  input  logic rx_neg_in,
  input  logic low_amp_in,
  input  logic osc_present,
  output logic los_out,
  output logic rx_pos_out,
  output logic rx_neg_out
);
  localparam int CNT_W = $clog2(THRESH + 1);

  // Named internal events, brought out for the checker.
  logic             mark_seen;
  logic [CNT_W-1:0] zero_run;
  logic             zero_los;
  logic             amp_low_sync;

  assign mark_seen = rx_pos_in | rx_neg_in;

  t1los_zero_run #(.THRESH(THRESH), .CNT_W(CNT_W)) u_zero_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_stb    (bit_stb),
    .mark_seen  (mark_seen),
    .osc_present(osc_present),
    .run_len    (zero_run),
    .run_los    (zero_los)
  );

  t1los_sync #(.STAGES(SYNC_STAGES)) u_amp_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (low_amp_in),
    .q    (amp_low_sync)
  );

  assign los_out = zero_los | amp_low_sync;

  t1los_rail_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_stb(bit_stb),
    .pos_in (rx_pos_in),
    .neg_in (rx_neg_in),
    .squelch(los_out),
    .pos_out(rx_pos_out),
    .neg_out(rx_neg_out)
  );
endmodule

// File: rtl/t1_los_detect_chk.sv
module t1_los_detect_chk #(
  parameter int THRESH = 175,
  parameter int CNT_W  = $clog2(THRESH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_stb,
  input logic             mark_seen,
  input logic             osc_present,
  input logic [CNT_W-1:0] zero_run,
  input logic             amp_low_sync,
  input logic             los_out,
  input logic             rx_pos_out,
  input logic             rx_neg_out
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !mark_seen && osc_present && (32'(zero_run) < THRESH))
      |=> (32'(zero_run) == 32'($past(zero_run)) + 1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && osc_present) |=> $stable(zero_run));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(zero_run) <= THRESH);

  p_reach_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(zero_run) == THRESH) |-> los_out);

  p_mark_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && mark_seen) |=> (zero_run == '0));

  p_osc_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_present |=> (zero_run == '0));

  p_amp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    amp_low_sync |-> los_out);

  p_squelch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    los_out |-> (!rx_pos_out && !rx_neg_out));
endmodule

bind t1_los_detect t1_los_detect_chk #(.THRESH(THRESH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_stb     (bit_stb),
  .mark_seen   (mark_seen),
  .osc_present (osc_present),
  .zero_run    (zero_run),
  .amp_low_sync(amp_low_sync),
  .los_out     (los_out),
  .rx_pos_out  (rx_pos_out),
  .rx_neg_out  (rx_neg_out)
);

// File: tb/t1_los_detect_bench.sv
`timescale 1ns/1ps
module t1_los_detect_bench;
  localparam int THRESH = 175;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, rx_pos_in = 1'b0, rx_neg_in = 1'b0;
  logic low_amp_in = 1'b0, osc_present = 1'b1;
  logic los_out, rx_pos_out, rx_neg_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  t1_los_detect #(.THRESH(THRESH), .SYNC_STAGES(2)) u_t1_los_detect (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
    .rx_pos_in(rx_pos_in), .rx_neg_in(rx_neg_in),
    .low_amp_in(low_amp_in), .osc_present(osc_present),
    .los_out(los_out), .rx_pos_out(rx_pos_out), .rx_neg_out(rx_neg_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One bit period: strobe high for one clock, then sampled at the next negedge.
  task automatic send_bit(input logic p, input logic n);
    @(negedge clk);
    bit_stb = 1'b1; rx_pos_in = p; rx_neg_in = n;
    @(negedge clk);
    bit_stb = 1'b0; rx_pos_in = 1'b0; rx_neg_in = 1'b0;
  endtask

  task automatic send_zeros(input int cnt);
    for (int i = 0; i < cnt; i++) send_bit(1'b0, 1'b0);
  endtask

  task automatic idle(input int cnt);
    repeat (cnt) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 los after reset", los_out, 1'b0);
    chk("R1 pos after reset", rx_pos_out, 1'b0);
    chk("R1 neg after reset", rx_neg_out, 1'b0);
    send_zeros(THRESH - 1);
    chk("R1 run starts at zero (THRESH-1 zeros)", los_out, 1'b0);
    send_bit(1'b1, 1'b0);
  endtask

  task automatic t_threshold();
    send_zeros(THRESH - 1);
    chk("R2 no loss at THRESH-1 zeros", los_out, 1'b0);
    idle(20);
    chk("R2 idle cycles do not advance run", los_out, 1'b0);
    send_zeros(1);
    chk("R2 loss at THRESH zeros", los_out, 1'b1);
    chk("R8 pos squelched", rx_pos_out, 1'b0);
    send_zeros(30);
    chk("R3 loss held past threshold", los_out, 1'b1);
    send_bit(1'b1, 1'b0);
    chk("R4 pos pulse ends zero loss", los_out, 1'b0);
    chk("R9 pos captured", rx_pos_out, 1'b1);
    idle(5);
    chk("R9 pos held between strobes", rx_pos_out, 1'b1);
    send_zeros(1);
    chk("R9 pos follows next strobe", rx_pos_out, 1'b0);
  endtask

  task automatic t_neg_rail();
    send_zeros(THRESH);
    chk("R2 loss again", los_out, 1'b1);
    send_bit(1'b0, 1'b1);
    chk("R4 neg pulse ends zero loss", los_out, 1'b0);
    chk("R9 neg captured", rx_neg_out, 1'b1);
    chk("R9 pos low on neg bit", rx_pos_out, 1'b0);
    send_zeros(THRESH - 1);
    chk("R4 run restarted from zero", los_out, 1'b0);
    send_bit(1'b1, 1'b1);
  endtask

  task automatic t_osc();
    osc_present = 1'b0;
    send_zeros(THRESH + 25);
    chk("R5 no zero loss without osc", los_out, 1'b0);
    osc_present = 1'b1;
    send_zeros(THRESH - 1);
    chk("R5 run fresh after osc returns", los_out, 1'b0);
    @(negedge clk); osc_present = 1'b0;
    @(negedge clk); osc_present = 1'b1;
    send_zeros(1);
    chk("R5 osc gap cleared partial run", los_out, 1'b0);
    send_zeros(THRESH - 1);
    chk("R5 loss after full run", los_out, 1'b1);
    osc_present = 1'b0;
    @(negedge clk);
    chk("R5 osc drop ends zero loss in one clock", los_out, 1'b0);
    osc_present = 1'b1;
    send_bit(1'b1, 1'b0);
  endtask

  task automatic t_amp();
    @(negedge clk); low_amp_in = 1'b1;
    @(negedge clk);
    chk("R6 one clock: not yet", los_out, 1'b0);
    @(negedge clk);
    chk("R6 two clocks: loss", los_out, 1'b1);
    send_bit(1'b1, 1'b0);
    chk("R8 pos squelched under amp loss", rx_pos_out, 1'b0);
    chk("R8 neg squelched under amp loss", rx_neg_out, 1'b0);
    chk("R7 amp holds loss", los_out, 1'b1);
    low_amp_in = 1'b0;
    @(negedge clk);
    chk("R6 release after one clock: still loss", los_out, 1'b1);
    @(negedge clk);
    chk("R6 release after two clocks", los_out, 1'b0);
    chk("R10 rail captured during loss shown", rx_pos_out, 1'b1);
  endtask

  task automatic t_both();
    send_zeros(THRESH);
    low_amp_in = 1'b1;
    idle(3);
    chk("R7 both sources", los_out, 1'b1);
    send_bit(1'b0, 1'b1);
    chk("R7 zero source cleared, amp holds loss", los_out, 1'b1);
    chk("R8 neg squelched", rx_neg_out, 1'b0);
    low_amp_in = 1'b0;
    idle(2);
    chk("R7 loss ends with both cleared", los_out, 1'b0);
    chk("R10 neg captured during loss shown", rx_neg_out, 1'b1);
    send_zeros(THRESH);
    idle(1);
    chk("R7 zero source alone", los_out, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_neg_rail();
    t_osc();
    t_amp();
    t_both();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule